// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the shifting half of a rotate-and-mask integer operation. It rotates a 64-bit operand left by a 6-bit amount and builds a bit mask from a start position and an end position. It returns three outputs: the rotated word, the mask, and their AND, which is the rotate-and-mask result. All three are purely combinational.

Bit positions are numbered big-endian: position 0 is the most significant bit. When the start position is greater than the end position, the mask wraps around the word. A single select input picks the full 64-bit word mode or a 32-bit word mode. In 32-bit mode the low operand word is copied into both halves before the rotate, and the mask positions count within the low word.

Top module: `rotmask_unit`

## Requirements
- R1: Mask position p drives output bit 63-p, so position 0 is the MSB. Start 0 and end 0 give 0x8000000000000000, and start 63 and end 63 give 0x0000000000000001.
- R2: When start < end, the mask holds ones from start through end inclusive and zeros elsewhere. Start 37 and end 63 give 0x0000000007FFFFFF.
- R3: When start > end, the mask holds ones from start through 63 and from 0 through end. Start 47 and end 37 give 0xFFFFFFFFFC01FFFF.
- R4: When start equals end, exactly one mask bit is set, at that position. Start 33 and end 33 give 0x0000000040000000.
- R5: With `half_mode`=1, each position input uses only its low 5 bits, and 32 is added before the mask is formed. The top bit of each position input has no effect. Start 5 and end 15 give 0x0000000007FF0000.
- R6: With `half_mode`=0, `rot_out` is the operand rotated left by `rot_amt` (0..63). Bits leaving the MSB re-enter at the LSB. 0xDEADBEEF12345678 rotated by 10 gives 0xB6FBBC48D159E37A, and by 35 gives 0x91A2B3C6F56DF778.
- R7: With `half_mode`=1, the low 32 operand bits fill both halves of a 64-bit word, and that word is rotated as in R6. The upper 32 operand bits have no effect. Operand low word 0xDEADBEEF rotated by 10 gives 0xB6FBBF7AB6FBBF7A.
- R8: `res_out` equals `rot_out` AND `mask_out` in every case.
- R9: The block holds no state. The outputs depend only on the present inputs, and a repeated input vector gives identical outputs whatever came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_opnd | input | 64 | Operand to rotate |
| rot_amt | input | 6 | Left-rotate amount |
| half_mode | input | 1 | 0: 64-bit word, 1: 32-bit word |
| beg_pos | input | 6 | Mask start position (big-endian) |
| fin_pos | input | 6 | Mask end position (big-endian) |
| rot_out | output | 64 | Rotated word |
| mask_out | output | 64 | Generated mask |
| res_out | output | 64 | Rotated word AND mask |

## Verification
The rotate and the mask wrap meet in a single evaluation when `half_mode`=1 and the start position exceeds the end position. The wrapped mask then reaches into the upper half, so the duplicated upper copy of the rotated word appears in `res_out`. Directed vectors with a wrapped range in 32-bit mode provoke this case, and so do random vectors in which the start is drawn above the end. Each result is judged against a bit-loop model of the rotate and the mask that is computed inside the bench.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
   typedef enum logic {
      RM_FULL = 1'b0,
      RM_HALF = 1'b1
   } rm_width_e;
endpackage

// File: rtl/rotmask_prep.sv
module rotmask_prep #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] din,
   input  logic              half_mode,
   output logic [DATA_W-1:0] dout
);
   import rotmask_pkg::*;
   localparam int HALF_W = DATA_W / 2;
   rm_width_e width_sel;
   assign width_sel = rm_width_e'(half_mode);
   always_comb begin
      if (width_sel == RM_HALF) dout = {din[HALF_W-1:0], din[HALF_W-1:0]};
      else                      dout = din;
   end
endmodule

// File: rtl/rotmask_barrel.sv
module rotmask_barrel #(
   parameter int DATA_W = 64,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] dout
);
   always_comb begin
      logic [DATA_W-1:0] tmp;
      tmp = din;
      for (int k = 0; k < AMT_W; k++) begin
         if (amt[k]) tmp = (tmp << (1 << k)) | (tmp >> (DATA_W - (1 << k)));
      end
      dout = tmp;
   end
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int DATA_W = 64,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [AMT_W-1:0]  beg_pos,
   input  logic [AMT_W-1:0]  fin_pos,
   input  logic              half_mode,
   output logic [DATA_W-1:0] mask
);
   logic [AMT_W-1:0] b_eff, f_eff;
   logic             wrap;

   assign b_eff = half_mode ? {1'b1, beg_pos[AMT_W-2:0]} : beg_pos;
   assign f_eff = half_mode ? {1'b1, fin_pos[AMT_W-2:0]} : fin_pos;
   assign wrap  = b_eff > f_eff;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [AMT_W-1:0] IDX = AMT_W'(i);
      logic ge_b, le_f;
      assign ge_b = IDX >= b_eff;
      assign le_f = IDX <= f_eff;
      assign mask[DATA_W-1-i] = wrap ? (ge_b | le_f) : (ge_b & le_f);
   end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
   parameter int DATA_W = 64,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src_opnd,
   input  logic [AMT_W-1:0]  rot_amt,
   input  logic              half_mode,
   input  logic [AMT_W-1:0]  beg_pos,
   input  logic [AMT_W-1:0]  fin_pos,
   output logic [DATA_W-1:0] rot_out,
   output logic [DATA_W-1:0] mask_out,
   output logic [DATA_W-1:0] res_out
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $fatal(1, "rotmask_unit: DATA_W must be a power of two, at least 8");
   end

   logic [DATA_W-1:0] prep_word;

   rotmask_prep #(.DATA_W(DATA_W)) u_prep (
      .din(src_opnd), .half_mode(half_mode), .dout(prep_word));

   rotmask_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
      .din(prep_word), .amt(rot_amt), .dout(rot_out));

   rotmask_maskgen #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_mask (
      .beg_pos(beg_pos), .fin_pos(fin_pos), .half_mode(half_mode),
      .mask(mask_out));

   assign res_out = rot_out & mask_out;
endmodule

// File: rtl/rotmask_chk.sv
module rotmask_chk #(
   parameter int DATA_W = 64,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0] src_opnd,
   input logic [AMT_W-1:0]  rot_amt,
   input logic              half_mode,
   input logic [AMT_W-1:0]  beg_pos,
   input logic [AMT_W-1:0]  fin_pos,
   input logic [DATA_W-1:0] rot_out,
   input logic [DATA_W-1:0] mask_out,
   input logic [DATA_W-1:0] res_out
);
   localparam int HALF_W = DATA_W / 2;
   int b_i, f_i;
   always_comb begin
      b_i = half_mode ? HALF_W + int'(beg_pos[AMT_W-2:0]) : int'(beg_pos);
      f_i = half_mode ? HALF_W + int'(fin_pos[AMT_W-2:0]) : int'(fin_pos);

      // R4
      single_bit_chk: assert (b_i != f_i || $countones(mask_out) == 1);
      // R2
      span_count_chk: assert (b_i >= f_i || $countones(mask_out) == f_i - b_i + 1);
      // R3
      wrap_count_chk: assert (b_i <= f_i || $countones(mask_out) == DATA_W - (b_i - f_i) + 1);
      // R1
      start_bit_chk: assert (mask_out[DATA_W-1-b_i] == 1'b1);
      // R7
      half_dup_chk: assert (!half_mode || rot_out[DATA_W-1:HALF_W] == rot_out[HALF_W-1:0]);
      // R6
      zero_rot_chk: assert (half_mode || rot_amt != '0 || rot_out == src_opnd);
      // R8
      and_result_chk: assert (res_out == (rot_out & mask_out));
   end
endmodule

bind rotmask_unit rotmask_chk #(.DATA_W(DATA_W)) u_chk (
   .src_opnd(src_opnd), .rot_amt(rot_amt), .half_mode(half_mode),
   .beg_pos(beg_pos), .fin_pos(fin_pos), .rot_out(rot_out),
   .mask_out(mask_out), .res_out(res_out));

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [63:0] src_opnd = '0;
   logic [5:0]  rot_amt = '0;
   logic        half_mode = 1'b0;
   logic [5:0]  beg_pos = '0;
   logic [5:0]  fin_pos = '0;
   logic [63:0] rot_out, mask_out, res_out;

   rotmask_unit dut (
      .src_opnd(src_opnd), .rot_amt(rot_amt), .half_mode(half_mode),
      .beg_pos(beg_pos), .fin_pos(fin_pos), .rot_out(rot_out),
      .mask_out(mask_out), .res_out(res_out));

   typedef struct {
      logic [63:0] e_rot;
      logic [63:0] e_mask;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   function automatic logic [63:0] m_rot(logic [63:0] v, int n, bit h);
      logic [63:0] w;
      w = h ? {v[31:0], v[31:0]} : v;
      for (int i = 0; i < n; i++) w = {w[62:0], w[63]};
      return w;
   endfunction

   function automatic logic [63:0] m_mask(int b, int f, bit h);
      logic [63:0] m;
      int eb, ef;
      eb = h ? (b % 32) + 32 : b;
      ef = h ? (f % 32) + 32 : f;
      m = '0;
      for (int p = 0; p < 64; p++) begin
         if (eb <= ef) m[63-p] = (p >= eb && p <= ef);
         else          m[63-p] = (p >= eb || p <= ef);
      end
      return m;
   endfunction

   task automatic apply_exp(logic [63:0] op, int amt, bit h, int b, int f,
                            logic [63:0] er, logic [63:0] em, string tag);
      item_t it;
      @(posedge clk);
      src_opnd  <= op;
      rot_amt   <= 6'(amt);
      half_mode <= h;
      beg_pos   <= 6'(b);
      fin_pos   <= 6'(f);
      it.e_rot = er; it.e_mask = em; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic apply(logic [63:0] op, int amt, bit h, int b, int f, string tag);
      apply_exp(op, amt, h, b, f, m_rot(op, amt, h), m_mask(b, f, h), tag);
   endtask

   task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         cmp(it.tag, "rot",  rot_out,  it.e_rot);
         cmp(it.tag, "mask", mask_out, it.e_mask);
         cmp(it.tag, "res",  res_out,  it.e_rot & it.e_mask);   // R8
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Quiet-input state, R1
      apply_exp(64'h0, 0, 0, 0, 0, 64'h0, 64'h8000_0000_0000_0000, "R1 zero");
      apply_exp(ONES, 0, 0, 63, 63, ONES, 64'h1, "R1 lsb");
      apply_exp(ONES, 0, 0, 37, 63, ONES, 64'h0000_0000_07FF_FFFF, "R2");
      apply_exp(ONES, 0, 0, 0, 37, ONES, 64'hFFFF_FFFF_FC00_0000, "R2 top");
      apply_exp(ONES, 0, 0, 47, 37, ONES, 64'hFFFF_FFFF_FC01_FFFF, "R3");
      apply_exp(ONES, 0, 0, 62, 1, ONES, 64'hC000_0000_0000_0003, "R3 ends");
      apply_exp(ONES, 0, 0, 33, 33, ONES, 64'h0000_0000_4000_0000, "R4");
      apply_exp(ONES, 0, 1, 5, 15, ONES, 64'h0000_0000_07FF_0000, "R5");
      apply_exp(ONES, 0, 1, 37, 47, ONES, 64'h0000_0000_07FF_0000, "R5 top ignored");
      apply_exp(ONES, 0, 1, 0, 1, ONES, 64'h0000_0000_C000_0000, "R5 first");
      apply_exp(64'hDEADBEEF12345678, 10, 0, 0, 63, 64'hB6FBBC48D159E37A, ONES, "R6 by10");
      apply_exp(64'hDEADBEEF12345678, 35, 0, 0, 63, 64'h91A2B3C6F56DF778, ONES, "R6 by35");
      apply_exp(64'hDEADBEEF12345678, 0, 0, 0, 63, 64'hDEADBEEF12345678, ONES, "R6 by0");
      apply_exp(64'h12345678DEADBEEF, 10, 1, 0, 31, 64'hB6FBBF7AB6FBBF7A,
                64'h0000_0000_FFFF_FFFF, "R7");
      apply_exp(64'hFFFFFFFFDEADBEEF, 10, 1, 0, 31, 64'hB6FBBF7AB6FBBF7A,
                64'h0000_0000_FFFF_FFFF, "R7 upper ignored");
      // wrap in 32-bit mode reaches the duplicated upper half (R3, R5, R7)
      apply(64'h0123456789ABCDEF, 4, 1, 15, 5, "R3 R7 wrap half");
      apply(64'h0123456789ABCDEF, 63, 1, 31, 0, "R3 R7 wrap full");
      // R9: same vector after unrelated traffic
      apply(64'hCAFEF00D55AA33CC, 17, 0, 40, 9, "R9 first");
      apply(64'h0, 0, 1, 3, 3, "R9 between");
      apply(ONES, 63, 0, 63, 0, "R9 between");
      apply(64'hCAFEF00D55AA33CC, 17, 0, 40, 9, "R9 repeat");
      for (int i = 0; i < 400; i++) begin
         logic [63:0] op;
         op = {$urandom, $urandom};
         apply(op, $urandom_range(0, 63), i[0], $urandom_range(0, 63),
               $urandom_range(0, 63), i[0] ? "R7 R5 random" : "R6 R2 R3 random");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule